// File: doc/BRIEF.md
# Transmit Triple-Replication Gearbox

This block sits in front of a 10-bit parallel serializer interface that runs at three times the rate of the data source. Each incoming 10-bit word is widened to 30 bits by repeating every bit three times. The wide word is then sent as three 10-bit words on consecutive fast-clock cycles. The effective line rate is therefore one third of the rate the serializer is configured for. A receiver that samples three times per bit can recover the original stream by majority or unanimity decoding.

The slow and fast rates come from the same clock source, so the block runs entirely on the fast clock. A strobe marks the cycles that carry a new input word; in steady state it is high one cycle in three. A two-entry buffer of 30-bit words absorbs jitter in the strobe phase. When no word is ready at a word boundary, the block sends a fixed idle pattern and raises an underrun flag. A word that arrives while the buffer is full is dropped and reported with an overflow flag. An error-injection pulse inverts all three copies of one chosen bit in the next word that is strobed in. Downstream error counters can be exercised this way.

Top module: `tx_triple_gearbox`

## Requirements
- R1: Input bit i appears on bits 3i, 3i+1 and 3i+2 of the 30-bit expanded word; for example, input 0x155 expands to 0x071C71C7 and input 0x3E0 expands to 0x3FFF8000.
- R2: The expanded word leaves on out_data as three consecutive 10-bit slices, bits 9:0 first, then 19:10, then 29:20. When the buffer is empty and no word is in progress, a word strobed at clock edge k shows its first slice after edge k+1.
- R3: With in_valid high exactly one cycle in every three, out_data carries back-to-back slices with no idle cycles and out_underrun stays low. Once a word's first slice has gone out, its remaining two slices follow without a gap.
- R4: Up to two expanded words wait in the buffer and leave in arrival order, so a burst of strobes on consecutive cycles is not lost while space remains.
- R5: At a word boundary with the buffer empty, out_data shows the idle pattern 0x155 and out_underrun is high for that cycle.
- R6: A strobe that finds the buffer full, in a cycle where no word is removed, drops that word. out_overflow is high on the following cycle only, and the dropped word never appears on out_data.
- R7: A one-cycle pulse on err_inject arms a single corruption. The next strobed word has all three copies of input bit 0 inverted (output bits 2:0 of its first slice), and the word after it is clean.
- R8: While rst_n is low, out_data shows the idle pattern 0x155, both flags are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one cycle per output word |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word strobe; loads in_data this cycle |
| in_data | input | 10 | Source data word |
| err_inject | input | 1 | Pulse to corrupt one bit triplet of the next loaded word |
| out_data | output | 10 | Word toward the serializer |
| out_underrun | output | 1 | High when an idle word is sent for lack of data |
| out_overflow | output | 1 | Pulses one cycle after an input word was dropped |

## Verification
The bench targets these corner cases:
- **Bit mapping.** Single-bit and edge-bit words such as 0x001, 0x200 and 0x3E0 expose a triplet placed at the wrong offset or a slice emitted in the wrong order. Either fault would show as bits landing in the wrong slice.
- **Burst into a full buffer.** Four back-to-back strobes fill the buffer. A design that overwrote an entry instead of dropping the newcomer would emit the fourth word, or lose the third. A design that raised the overflow flag late would show it on the wrong cycle.
- **Underrun at the buffer tail.** After the burst drains, the cycle where idle and the underrun flag must appear is checked.
- **Error-injection span.** Injection is checked on both the corrupted word and the clean word after it. A one-shot that was not consumed on use would corrupt the second word as well.

// File: rtl/txg_pkg.sv
package txg_pkg;
   localparam int unsigned TXG_IN_W  = 10;
   localparam int unsigned TXG_REP   = 3;
   localparam int unsigned TXG_DEPTH = 2;
   localparam logic [9:0]  TXG_IDLE  = 10'h155;
endpackage

// File: rtl/txg_replicate.sv
module txg_replicate #(
   parameter int unsigned IN_W     = 10,
   parameter int unsigned REP      = 3,
   parameter int unsigned FLIP_IDX = 0,
   localparam int unsigned OUT_W   = IN_W * REP
) (
   input  logic [IN_W-1:0]  din,
   input  logic             flip,
   output logic [OUT_W-1:0] wide
);
   if (FLIP_IDX >= IN_W) begin : g_bad_flip
      $error("txg_replicate: FLIP_IDX out of range");
   end

   for (genvar i = 0; i < IN_W; i++) begin : g_bit
      if (i == FLIP_IDX) begin : g_flip
         assign wide[i*REP +: REP] = {REP{din[i] ^ flip}};
      end else begin : g_plain
         assign wide[i*REP +: REP] = {REP{din[i]}};
      end
   end
endmodule

// File: rtl/txg_wordbuf.sv
module txg_wordbuf #(
   parameter int unsigned W     = 30,
   parameter int unsigned DEPTH = 2,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("txg_wordbuf: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          do_wr, do_rd;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_rd   = rd_en && !empty;
   assign do_wr   = wr_en && (!full || do_rd);
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);  // R4
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));  // R4
endmodule

// File: rtl/txg_slicer.sv
module txg_slicer #(
   parameter int unsigned IN_W = 10,
   parameter int unsigned REP  = 3,
   parameter logic [IN_W-1:0] IDLE = '0,
   localparam int unsigned W   = IN_W * REP,
   localparam int unsigned SW  = $clog2(REP)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    word_in,
   input  logic            avail,
   output logic            pop,
   output logic [IN_W-1:0] out_data,
   output logic            underrun
);
   if (REP < 2) begin : g_bad_rep
      $error("txg_slicer: REP must be at least 2");
   end

   localparam logic [SW-1:0] LAST = SW'(REP - 1);

   logic [W-1:0]  held;
   logic [SW-1:0] sidx;

   assign pop = (sidx == '0) && avail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held     <= '0;
         sidx     <= '0;
         out_data <= IDLE;
         underrun <= 1'b0;
      end else if (sidx != '0) begin
         out_data <= held[int'(sidx)*IN_W +: IN_W];
         underrun <= 1'b0;
         sidx     <= (sidx == LAST) ? '0 : sidx + 1'b1;
      end else if (avail) begin
         held     <= word_in;
         out_data <= word_in[IN_W-1:0];
         underrun <= 1'b0;
         sidx     <= SW'(1);
      end else begin
         out_data <= IDLE;
         underrun <= 1'b1;
      end
   end

   AST_UNDERRUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (out_data == IDLE));  // R5
   AST_NO_GAP_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
      (sidx != '0) |=> !underrun);  // R3
endmodule

// File: rtl/tx_triple_gearbox.sv
module tx_triple_gearbox
   import txg_pkg::*;
#(
   parameter int unsigned IN_W     = TXG_IN_W,
   parameter int unsigned REP      = TXG_REP,
   parameter int unsigned DEPTH    = TXG_DEPTH,
   parameter int unsigned FLIP_IDX = 0,
   parameter logic [IN_W-1:0] IDLE = IN_W'(TXG_IDLE)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [IN_W-1:0] in_data,
   input  logic            err_inject,
   output logic [IN_W-1:0] out_data,
   output logic            out_underrun,
   output logic            out_overflow
);
   localparam int unsigned W = IN_W * REP;

   logic [W-1:0] wide, head;
   logic         err_arm, buf_empty, buf_full, pop;

   always_ff @(posedge clk) begin
      if (!rst_n)          err_arm <= 1'b0;
      else if (in_valid)   err_arm <= 1'b0;
      else if (err_inject) err_arm <= 1'b1;
   end

   txg_replicate #(.IN_W(IN_W), .REP(REP), .FLIP_IDX(FLIP_IDX)) u_rep (
      .din  (in_data),
      .flip (err_arm | err_inject),
      .wide (wide)
   );

   txg_wordbuf #(.W(W), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid),
      .wr_data (wide),
      .rd_en   (pop),
      .rd_data (head),
      .empty   (buf_empty),
      .full    (buf_full)
   );

   txg_slicer #(.IN_W(IN_W), .REP(REP), .IDLE(IDLE)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_in  (head),
      .avail    (!buf_empty),
      .pop      (pop),
      .out_data (out_data),
      .underrun (out_underrun)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) out_overflow <= 1'b0;
      else        out_overflow <= in_valid && buf_full && !pop;
   end

   AST_INJECT_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> !err_arm);  // R7
   AST_OVERFLOW_NOT_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      out_overflow |-> !out_underrun);  // R6
endmodule

// File: tb/tx_triple_gearbox_bench.sv
`timescale 1ns/1ps
module tx_triple_gearbox_bench;
   localparam logic [9:0] IDLE = 10'h155;
   localparam int N = 8;
   typedef struct packed { logic [9:0] din; logic [29:0] exp; } vec_t;
   localparam vec_t TAB [N] = '{
      '{10'h000, 30'h0000_0000}, '{10'h3FF, 30'h3FFF_FFFF},
      '{10'h155, 30'h071C_71C7}, '{10'h2AA, 30'h38E3_8E38},
      '{10'h001, 30'h0000_0007}, '{10'h200, 30'h3800_0000},
      '{10'h3E0, 30'h3FFF_8000}, '{10'h01F, 30'h0000_7FFF}};

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, err_inject = 1'b0;
   logic [9:0] in_data = '0, out_data;
   logic out_underrun, out_overflow;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tx_triple_gearbox u_tx_triple_gearbox (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .err_inject(err_inject), .out_data(out_data),
      .out_underrun(out_underrun), .out_overflow(out_overflow));

   task automatic check(input string tag, input logic [29:0] got, input logic [29:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input logic v, input logic [9:0] d, input logic inj);
      in_valid = v; in_data = d; err_inject = inj;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; err_inject = 1'b0;
   endtask

   task automatic expect_out(input string tag, input logic [9:0] d, input logic ur, input logic ov);
      check({tag, " data"}, 30'(out_data), 30'(d));
      check({tag, " underrun"}, 30'(out_underrun), 30'(ur));
      check({tag, " overflow"}, 30'(out_overflow), 30'(ov));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_out("R8 reset", IDLE, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      expect_out("R5 idle after reset", IDLE, 1'b1, 1'b0);

      // R1 R2 R3: table stream, strobe one cycle in three
      for (int c = 0; c <= 3*N; c++) begin
         step((c % 3 == 0) && (c / 3 < N), TAB[(c / 3) % N].din, 1'b0);
         if (c == 0) expect_out("R5 first slot empty", IDLE, 1'b1, 1'b0);
         else expect_out($sformatf("R1/R2/R3 word %0d slice %0d", (c-1)/3, (c-1)%3),
                         TAB[(c-1)/3].exp[((c-1)%3)*10 +: 10], 1'b0, 1'b0);
      end
      step(1'b0, '0, 1'b0);
      expect_out("R5 stream drained", IDLE, 1'b1, 1'b0);

      // R4 R6: burst of four strobes into a two-entry buffer
      step(1'b1, 10'h001, 1'b0); expect_out("R5 burst start", IDLE, 1'b1, 1'b0);
      step(1'b1, 10'h200, 1'b0); expect_out("R4 A s0", 10'h007, 1'b0, 1'b0);
      step(1'b1, 10'h3E0, 1'b0); expect_out("R4 A s1", 10'h000, 1'b0, 1'b0);
      step(1'b1, 10'h3FF, 1'b0); expect_out("R6 A s2 overflow", 10'h000, 1'b0, 1'b1);
      step(1'b0, '0, 1'b0);      expect_out("R6 B s0 flag clears", 10'h000, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R4 B s1", 10'h000, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R4 B s2", 10'h380, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R4 C s0", 10'h000, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R4 C s1", 10'h3E0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R4 C s2", 10'h3FF, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R6 dropped word absent", IDLE, 1'b1, 1'b0);

      // R7: one-shot error injection
      step(1'b0, '0, 1'b1);      expect_out("R7 arm idle", IDLE, 1'b1, 1'b0);
      step(1'b1, 10'h000, 1'b0); expect_out("R7 load", IDLE, 1'b1, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R7 corrupted s0", 10'h007, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R7 corrupted s1", 10'h000, 1'b0, 1'b0);
      step(1'b1, 10'h000, 1'b0); expect_out("R7 corrupted s2", 10'h000, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0);      expect_out("R7 next word clean", 10'h000, 1'b0, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule